// File: doc/BRIEF.md
# Fractional-N Feedback Divider Chain

This block is the programmable feedback divider of a fractional-N frequency synthesizer. It runs on a fast input clock that stands in for the oscillator output. It produces one divided pulse per output cycle, together with the modulus-control signal that a dual-modulus prescaler would receive. Inside, a behavioural prescaler divides by P or P+1. A period counter runs through M prescaler periods per output cycle, and a swallow count selects how many of those periods use P+1. A 5-bit fractional accumulator adds one extra swallow each time it wraps. Over time the average ratio comes to P·M + A + F/32.

The parameter P_MOD picks a prescaler base of 32 or 16, and the swallow input is then 5 or 4 bits wide. Even fractional numerators reduce by themselves: 12/32 repeats every 8 output cycles, as 3/8 would. So the usable denominators are 2, 4, 8, 16 and 32. For every integer ratio to be reachable, the total ratio must be at least 1024 with P = 32, or at least 256 with P = 16.

A new M, A and F set is offered with a one-clock load strobe. The set takes effect only where one output cycle ends and the next begins. The strobe has no handshake. A holding register always accepts it, so there is no back-pressure. A newer strobe before the cycle boundary replaces a waiting one. There is no data stream at this block's edge, so every pin is a plain control or status signal.

Top module: `fracn_fb_div`

## Requirements
- R1: While reset is held, div_pulse, mod_hi and cfg_err are low. Reset sets the active configuration to M = RST_M, A = 0 and F = 0, so the first output cycle after reset lasts P·RST_M input clocks.
- R2: Each output cycle lasts P·M + A' input clocks, where A' is the swallow count in force for that cycle (A' = A, or A+1 after a carry; if A' would exceed M, all M periods are long). div_pulse is high on the last input clock of each cycle only.
- R3: mod_hi is high throughout the first A' prescaler periods of a cycle, each P+1 clocks long, and low in the remaining periods, each P clocks long. mod_hi is therefore high for A'·(P+1) clocks per cycle.
- R4: At each cycle boundary the 5-bit accumulator adds F modulo 32. A sum of 32 or more (a carry out of bit 4) makes A' = A+1 for the next cycle.
- R5: Over any 32 consecutive output cycles with a constant configuration, the input-clock count is exactly 32·(P·M + A) + F.
- R6: For an even F the carry pattern repeats with a shorter period. With F = 12, any 8 consecutive cycles total 8·(P·M + A) + 3 clocks.
- R7: A load strobe applies cfg_m, cfg_a and cfg_f at the next cycle boundary, and the cycle in progress finishes with the old values. A strobe on the boundary clock itself applies at that boundary. A second strobe before the boundary replaces the first.
- R8: Applying a configuration clears the accumulator and the pending carry. The first two cycles after the apply therefore use A' = A.
- R9: cfg_err is high exactly when the active configuration has A ≥ M or M < 3, and it changes only when a configuration is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (stand-in for the oscillator) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-clock strobe offering a new configuration |
| cfg_m | input | M_W | Period count M per output cycle |
| cfg_a | input | log2(P_MOD) | Swallow count A |
| cfg_f | input | F_W | Fractional numerator F over 32 |
| div_pulse | output | 1 | High on the last input clock of each output cycle |
| mod_hi | output | 1 | Prescaler modulus control, high when dividing by P+1 |
| cfg_err | output | 1 | Active configuration has A ≥ M or M < 3 |

## Verification
Two functions can meet on the same clock: the end of an output cycle and the arrival of a load strobe. When they meet, the design must take the strobe values straight into the active set, without routing them through the holding register. The bench provokes this by raising cfg_load on the clock where div_pulse is high. The scoreboard then expects the very next cycle to use the new ratio with no carry. A neighbouring case puts two strobes inside one cycle, and the scoreboard expects only the later set to appear.

// File: rtl/fnd_pkg.sv
`timescale 1ns/1ps
package fnd_pkg;
  localparam int unsigned FRAC_W  = 5;
  localparam int unsigned MIN_M   = 3;

  // swallow counter width follows the prescaler base: 32 -> 5 bits, 16 -> 4 bits
  function automatic int unsigned swallow_width(input int unsigned pmod);
    return $clog2(pmod);
  endfunction

  // bits needed to count up to pmod inclusive (long prescaler period)
  function automatic int unsigned presc_width(input int unsigned pmod);
    return $clog2(pmod + 1);
  endfunction
endpackage

// File: rtl/fnd_prescaler.sv
`timescale 1ns/1ps
module fnd_prescaler #(
  parameter int unsigned P_MOD = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mod_hi,
  output logic pre_end
);
  localparam int unsigned PW = fnd_pkg::presc_width(P_MOD);
  localparam logic [PW-1:0] LAST_LO = PW'(P_MOD - 1);
  localparam logic [PW-1:0] LAST_HI = PW'(P_MOD);
  localparam logic [PW-1:0] ONE     = PW'(1);

  logic [PW-1:0] pc_q;

  // a period ends after P clocks, or P+1 while the modulus control is high
  assign pre_end = (pc_q == (mod_hi ? LAST_HI : LAST_LO));

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (pre_end) pc_q <= '0;
    else              pc_q <= pc_q + ONE;
  end

  AST_SHORT_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_hi |-> (pc_q < LAST_HI)); // R3
endmodule

// File: rtl/fnd_swallow.sv
`timescale 1ns/1ps
module fnd_swallow #(
  parameter int unsigned M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_end,
  input  logic [M_W-1:0] m_act,
  input  logic [M_W:0]   a_eff,
  output logic           mod_hi,
  output logic           last_period
);
  localparam logic [M_W-1:0] ONE = M_W'(1);

  logic [M_W-1:0] mc_q;

  assign last_period = (mc_q == (m_act - ONE));
  // long periods come first in every output cycle
  assign mod_hi      = ({1'b0, mc_q} < a_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) mc_q <= '0;
    else if (pre_end) begin
      if (last_period) mc_q <= '0;
      else             mc_q <= mc_q + ONE;
    end
  end

  AST_MODHI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_end |=> $stable(mod_hi)); // R3
endmodule

// File: rtl/fnd_accum.sv
`timescale 1ns/1ps
module fnd_accum #(
  parameter int unsigned F_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boundary,
  input  logic           apply,
  input  logic [F_W-1:0] f_act,
  output logic           carry
);
  logic [F_W-1:0] acc_q;
  logic           carry_q;
  logic [F_W:0]   sum;

  assign sum   = {1'b0, acc_q} + {1'b0, f_act};
  assign carry = carry_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (apply) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (boundary) begin
      acc_q   <= sum[F_W-1:0];
      carry_q <= sum[F_W];
    end
  end

  AST_CARRY_NEEDS_FRACTION: assert property (@(posedge clk) disable iff (!rst_n)
    carry_q |-> (f_act != '0)); // R4
  AST_APPLY_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (acc_q == '0) && !carry_q); // R8
endmodule

// File: rtl/fnd_cfg.sv
`timescale 1ns/1ps
module fnd_cfg #(
  parameter int unsigned M_W   = 9,
  parameter int unsigned A_W   = 5,
  parameter int unsigned F_W   = 5,
  parameter int unsigned RST_M = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boundary,
  input  logic           cfg_load,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  input  logic [F_W-1:0] cfg_f,
  output logic [M_W-1:0] m_act,
  output logic [M_W-1:0] a_act,
  output logic [F_W-1:0] f_act,
  output logic           apply,
  output logic           cfg_err
);
  localparam logic [M_W-1:0] MIN_M_V = M_W'(fnd_pkg::MIN_M);

  logic           pend_q;
  logic [M_W-1:0] stg_m, stg_a, in_a;
  logic [F_W-1:0] stg_f;

  assign in_a    = {{(M_W-A_W){1'b0}}, cfg_a};
  assign apply   = boundary && (cfg_load || pend_q);
  assign cfg_err = (a_act >= m_act) || (m_act < MIN_M_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      stg_m  <= '0;
      stg_a  <= '0;
      stg_f  <= '0;
      m_act  <= M_W'(RST_M);
      a_act  <= '0;
      f_act  <= '0;
    end else if (boundary) begin
      pend_q <= 1'b0;
      if (cfg_load) begin
        // strobe on the boundary clock bypasses the holding register
        m_act <= cfg_m;
        a_act <= in_a;
        f_act <= cfg_f;
      end else if (pend_q) begin
        m_act <= stg_m;
        a_act <= stg_a;
        f_act <= stg_f;
      end
    end else if (cfg_load) begin
      pend_q <= 1'b1;
      stg_m  <= cfg_m;
      stg_a  <= in_a;
      stg_f  <= cfg_f;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(m_act) && $stable(a_act) && $stable(f_act)); // R7
  AST_LOAD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cfg_load) |=> (m_act == $past(cfg_m)) && (f_act == $past(cfg_f))); // R7
  AST_PENDING_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && pend_q && !cfg_load) |=> (m_act == $past(stg_m)) && (a_act == $past(stg_a))); // R7
endmodule

// File: rtl/fracn_fb_div.sv
`timescale 1ns/1ps
module fracn_fb_div #(
  parameter int unsigned P_MOD = 32,
  parameter int unsigned M_W   = 9,
  parameter int unsigned F_W   = fnd_pkg::FRAC_W,
  parameter int unsigned RST_M = 8,
  localparam int unsigned A_W  = fnd_pkg::swallow_width(P_MOD)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  input  logic [F_W-1:0] cfg_f,
  output logic           div_pulse,
  output logic           mod_hi,
  output logic           cfg_err
);
  logic [M_W-1:0] m_act, a_act;
  logic [F_W-1:0] f_act;
  logic [M_W:0]   a_eff;
  logic           apply, carry, pre_end, last_period, boundary;

  assign boundary  = pre_end && last_period;
  assign div_pulse = boundary;
  assign a_eff     = {1'b0, a_act} + {{M_W{1'b0}}, carry};

  fnd_cfg #(.M_W(M_W), .A_W(A_W), .F_W(F_W), .RST_M(RST_M)) u_cfg (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .cfg_load(cfg_load),
    .cfg_m(cfg_m), .cfg_a(cfg_a), .cfg_f(cfg_f),
    .m_act(m_act), .a_act(a_act), .f_act(f_act), .apply(apply), .cfg_err(cfg_err)
  );

  fnd_accum #(.F_W(F_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .apply(apply),
    .f_act(f_act), .carry(carry)
  );

  fnd_prescaler #(.P_MOD(P_MOD)) u_presc (
    .clk(clk), .rst_n(rst_n), .mod_hi(mod_hi), .pre_end(pre_end)
  );

  fnd_swallow #(.M_W(M_W)) u_swallow (
    .clk(clk), .rst_n(rst_n), .pre_end(pre_end), .m_act(m_act),
    .a_eff(a_eff), .mod_hi(mod_hi), .last_period(last_period)
  );

  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse); // R2
  AST_SHORT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && (a_eff < {1'b0, m_act})) |-> !mod_hi); // R3
  AST_ERR_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_err) |-> $past(apply)); // R9
endmodule

// File: tb/fracn_fb_div_tb.sv
`timescale 1ns/1ps
module fracn_fb_div_tb;
  localparam int P     = 32;
  localparam int RST_M = 8;

  logic       clk = 1'b0, rst_n = 1'b0, cfg_load = 1'b0;
  logic [8:0] cfg_m = '0;
  logic [4:0] cfg_a = '0, cfg_f = '0;
  logic       div_pulse, mod_hi, cfg_err;

  fracn_fb_div #(.P_MOD(P), .RST_M(RST_M)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_m(cfg_m), .cfg_a(cfg_a),
    .cfg_f(cfg_f), .div_pulse(div_pulse), .mod_hi(mod_hi), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  int    checks = 0, fails = 0, pushed = 0, cnt = 0, hicnt = 0;
  int    e_len, e_hi;
  string e_tag;
  bit    done = 1'b0;
  int    q_len[$], q_hi[$], hist[$];
  string q_tag[$];

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // expected cycles of one configuration, accumulator cleared at apply
  task automatic push_phase(input int m, input int a, input int f, input int n, input string tag0);
    int acc = 0;
    int s, c, ae;
    for (int i = 0; i < n; i++) begin
      c = 0;
      if (i > 0) begin
        s = acc + f;
        c = (s >= 32) ? 1 : 0;
        acc = s % 32;
      end
      ae = a + c;
      if (ae > m) ae = m;
      q_len.push_back(P * m + ae);
      q_hi.push_back(ae * (P + 1));
      q_tag.push_back(i == 0 ? tag0 : (i == 1 ? "R8" : "R4"));
      pushed++;
    end
  endtask

  // monitor: measure each output cycle and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      cnt++;
      if (mod_hi) hicnt++;
      if (div_pulse) begin
        hist.push_back(cnt);
        if (q_len.size() == 0) begin
          chk(1'b0, "R2", "unexpected cycle length", cnt, 0);
        end else begin
          e_len = q_len.pop_front();
          e_hi  = q_hi.pop_front();
          e_tag = q_tag.pop_front();
          chk(cnt == e_len, e_tag, "cycle length (R2)", cnt, e_len);
          chk(hicnt == e_hi, "R3", "mod_hi clocks", hicnt, e_hi);
        end
        cnt = 0;
        hicnt = 0;
      end
    end
  end

  task automatic drive_cfg(input int m, input int a, input int f);
    cfg_m = 9'(m);
    cfg_a = 5'(a);
    cfg_f = 5'(f);
  endtask

  task automatic wait_last_old(input int n);
    while (q_len.size() > n + 1) @(posedge clk);
  endtask

  task automatic load_mid(input int m, input int a, input int f, input int n);
    push_phase(m, a, f, n, "R7");
    wait_last_old(n);
    #1;
    drive_cfg(m, a, f);
    cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
  endtask

  // strobe on the boundary clock itself
  task automatic load_bound(input int m, input int a, input int f, input int n);
    push_phase(m, a, f, n, "R7");
    wait_last_old(n);
    do @(negedge clk); while (!div_pulse);
    drive_cfg(m, a, f);
    cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
  endtask

  // two strobes inside one cycle, the later must win
  task automatic load_twice(input int m1, input int a1, input int f1,
                            input int m2, input int a2, input int f2, input int n);
    push_phase(m2, a2, f2, n, "R7");
    wait_last_old(n);
    #1;
    drive_cfg(m1, a1, f1);
    cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
    @(posedge clk);
    #1;
    drive_cfg(m2, a2, f2);
    cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
  endtask

  task automatic wait_err(input int n, input bit exp);
    while (q_len.size() > n - 1) @(posedge clk);
    @(negedge clk);
    chk(cfg_err == exp, "R9", "cfg_err", int'(cfg_err), int'(exp));
  endtask

  function automatic int hist_sum(input int start, input int len);
    int s = 0;
    for (int i = start; i < start + len; i++) s += hist[i];
    return s;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  int s_a, s_b;

  initial begin
    push_phase(RST_M, 0, 0, 3, "R1");
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!div_pulse, "R1", "div_pulse in reset", int'(div_pulse), 0);
    chk(!mod_hi, "R1", "mod_hi in reset", int'(mod_hi), 0);
    chk(!cfg_err, "R1", "cfg_err in reset", int'(cfg_err), 0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    s_a = pushed;
    load_mid(8, 3, 12, 34);
    wait_err(34, 1'b0);
    s_b = pushed;
    load_mid(33, 31, 31, 34);
    wait_err(34, 1'b0);
    load_bound(5, 4, 1, 6);
    wait_err(6, 1'b0);
    load_twice(20, 1, 7, 6, 2, 5, 6);
    wait_err(6, 1'b0);
    load_mid(3, 3, 0, 3);
    wait_err(3, 1'b1);
    load_mid(2, 0, 9, 3);
    wait_err(3, 1'b1);
    load_mid(4, 1, 16, 5);
    wait_err(5, 1'b0);
    while (q_len.size() > 0) @(posedge clk);

    // R6: F = 12 repeats every 8 cycles with 3 carries
    chk(hist_sum(s_a + 5, 8) == 8 * (P * 8 + 3) + 3, "R6", "8-cycle sum",
        hist_sum(s_a + 5, 8), 8 * (P * 8 + 3) + 3);
    // R5: 32 consecutive cycles carry exactly F extra clocks
    chk(hist_sum(s_a + 2, 32) == 32 * (P * 8 + 3) + 12, "R5", "32-cycle sum f=12",
        hist_sum(s_a + 2, 32), 32 * (P * 8 + 3) + 12);
    chk(hist_sum(s_b + 1, 32) == 32 * (P * 33 + 31) + 31, "R5", "32-cycle sum f=31",
        hist_sum(s_b + 1, 32), 32 * (P * 33 + 31) + 31);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d outstanding cycles expected 0", q_len.size());
      summary();
      $finish;
    end
  end
endmodule